// File: doc/BRIEF.md
# Non-Revertive Reference Failover Selector

This block decides which of two reference clock inputs feeds a PLL phase detector. In manual mode a select input picks the port directly. In automatic mode the block holds the port that was chosen when the mode was entered. It moves to the other port once, when the loss flag of the chosen port rises. After that single move it ignores the select input and makes no further move. A new move is possible only after the mode input has gone low and then high again.

The mode and select inputs are asynchronous and pass through a two-stage synchronizer. The per-port loss flags come from activity monitors in the same clock domain and are used directly. The block outputs three things: the current selection, the loss flag of the selected port, and a one-cycle pulse on every change of selection. A feedback divider uses the pulse to realign its phase after a reselection.

Top module: `refsel_failover`

## Requirements
- R1: With the mode input low, `sel_o` takes the value of `sel_req_i` three clock edges after the select input changes (two synchronizer stages plus the selection register). A value of 0 selects port 0 and 1 selects port 1.
- R2: `loss_o` equals `loss_i[sel_o]` in every cycle. Bit 0 of `loss_i` belongs to port 0 and bit 1 to port 1. There is no register between `loss_i` and `loss_o`.
- R3: While armed (mode input high, no failover made yet), `sel_o` keeps the value it had at arming, whatever `sel_req_i` does.
- R4: While armed, a clock edge at which `loss_i[sel_o]` is high inverts `sel_o` and ends the armed state.
- R5: After a failover, `sel_o` stays where it is, even if the new port's loss flag is also high. In that case `loss_o` stays high.
- R6: After a failover, changes on `sel_req_i` have no effect on `sel_o` while the mode input stays high.
- R7: The block returns to manual mode when the synchronized mode input goes low, and `sel_o` then follows `sel_req_i`. A later rise of the mode input arms a new single failover.
- R8: `chg_pulse_o` is high for exactly the cycles in which `sel_o` holds a value different from the previous cycle. This applies in both manual and automatic modes.
- R9: While `rst` is high, the block is in manual mode, `sel_o` equals `sel_req_i` and `chg_pulse_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the activity monitors |
| rst | input | 1 | Synchronous reset, active high |
| auto_mode_i | input | 1 | 1 = automatic failover mode, 0 = manual (asynchronous) |
| sel_req_i | input | 1 | Requested port in manual mode (asynchronous) |
| loss_i | input | 2 | Per-port loss-of-activity flags, bit n belongs to port n |
| sel_o | output | 1 | Port currently routed to the phase detector |
| loss_o | output | 1 | Loss flag of the routed port |
| chg_pulse_o | output | 1 | One-cycle pulse on every change of selection |

## Verification
The random phase toggles the mode, select and loss inputs at different rates, so that every mode meets faults, select changes and re-arm cycles. This separates a design that keeps ignoring the select input from one that obeys it too early or too late. Directed sequences cover the corner cases. One arms the block and kills the selected port, which shows that exactly one move is made. Another kills both ports, which shows that no second move follows. A third toggles the select input after a failover, which shows it is ignored. The last drops the mode input and raises it again, which shows a fresh failover is allowed only after that low-then-high cycle. A bench reference model, advanced one clock edge at a time, supplies the expected selection, loss and pulse values.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    ST_MANUAL   = 2'd0,
    ST_ARMED    = 2'd1,
    ST_SWITCHED = 2'd2
  } sel_state_e;

  // loss flag of the given port
  function automatic logic port_loss(input logic [1:0] loss, input logic port);
    return loss[port];
  endfunction

  // port opposite to the given one
  function automatic logic other_port(input logic port);
    return ~port;
  endfunction

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) stage_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) stage_q[s] <= d_i;
          else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       auto_s,
  input  logic       req_s,
  input  logic       req_raw,
  input  logic [1:0] loss_i,
  output logic       sel_q,
  output logic       chg_q,
  output sel_state_e state_q,
  output logic       fail_evt
);
  sel_state_e state_d;
  logic       sel_d;
  logic       cur_loss;

  assign cur_loss = port_loss(loss_i, sel_q);
  assign fail_evt = (state_q == ST_ARMED) && auto_s && cur_loss;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    unique case (state_q)
      ST_MANUAL: begin
        sel_d = req_s;
        if (auto_s) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (!auto_s) begin
          state_d = ST_MANUAL;
          sel_d   = req_s;
        end else if (fail_evt) begin
          state_d = ST_SWITCHED;
          sel_d   = other_port(sel_q);
        end
      end
      ST_SWITCHED: begin
        if (!auto_s) begin
          state_d = ST_MANUAL;
          sel_d   = req_s;
        end
      end
      default: begin
        state_d = ST_MANUAL;
        sel_d   = req_s;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_MANUAL;
      sel_q   <= req_raw;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      chg_q   <= (sel_d != sel_q);
    end
  end
endmodule

// File: rtl/refsel_failover.sv
module refsel_failover
  import refsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       auto_mode_i,
  input  logic       sel_req_i,
  input  logic [1:0] loss_i,
  output logic       sel_o,
  output logic       loss_o,
  output logic       chg_pulse_o
);
  localparam int CTRL_W = 2;

  logic [CTRL_W-1:0] ctrl_s;
  logic              auto_s;
  logic              req_s;
  logic              sel_q;
  logic              chg_q;
  logic              fail_evt;
  sel_state_e        state_q;

  refsel_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({auto_mode_i, sel_req_i}),
    .q_o (ctrl_s)
  );

  assign auto_s = ctrl_s[1];
  assign req_s  = ctrl_s[0];

  refsel_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .auto_s   (auto_s),
    .req_s    (req_s),
    .req_raw  (sel_req_i),
    .loss_i   (loss_i),
    .sel_q    (sel_q),
    .chg_q    (chg_q),
    .state_q  (state_q),
    .fail_evt (fail_evt)
  );

  assign sel_o       = sel_q;
  assign loss_o      = port_loss(loss_i, sel_q);
  assign chg_pulse_o = chg_q;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk
  import refsel_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_s,
  input logic       fail_evt,
  input sel_state_e state_q,
  input logic       sel_o,
  input logic       chg_pulse_o
);
  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state_q) == ST_MANUAL) |-> (sel_o == $past(req_s))); // R1

  AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_ARMED && state_q == ST_ARMED) |-> $stable(sel_o)); // R3

  AST_FAILOVER_FLIP: assert property (@(posedge clk) disable iff (rst)
    fail_evt |=> (sel_o != $past(sel_o)) && (state_q == ST_SWITCHED)); // R4

  AST_SINGLE_MOVE: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_SWITCHED && state_q == ST_SWITCHED) |-> $stable(sel_o)); // R5

  AST_REARM_VIA_MANUAL: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_SWITCHED) |-> (state_q != ST_ARMED)); // R7

  AST_PULSE_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (chg_pulse_o == (sel_o != $past(sel_o)))); // R8
endmodule

bind refsel_failover refsel_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_s       (req_s),
  .fail_evt    (fail_evt),
  .state_q     (state_q),
  .sel_o       (sel_o),
  .chg_pulse_o (chg_pulse_o)
);

// File: tb/tb_refsel_failover.sv
module tb_refsel_failover;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       auto_mode_i = 1'b0;
  logic       sel_req_i = 1'b0;
  logic [1:0] loss_i = 2'b00;
  logic       sel_o, loss_o, chg_pulse_o;

  int n_run  = 0;
  int n_fail = 0;

  // bench reference model
  logic m_a [SYNC];
  logic m_r [SYNC];
  int   m_mode = 0; // 0 manual, 1 armed, 2 switched
  logic m_sel = 1'b0;
  logic m_chg = 1'b0;

  always #4 clk = ~clk;

  refsel_failover dut (
    .clk (clk), .rst (rst), .auto_mode_i (auto_mode_i), .sel_req_i (sel_req_i),
    .loss_i (loss_i), .sel_o (sel_o), .loss_o (loss_o), .chg_pulse_o (chg_pulse_o)
  );

  function automatic string sel_tag(input int mode);
    if (mode == 0) return "R1";
    if (mode == 1) return "R3/R4";
    return "R5/R6";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // model of one clock edge with the inputs applied now
  task automatic model_edge(input logic a, input logic r, input logic [1:0] l);
    logic ns;
    int   nm;
    if (rst) begin
      for (int i = 0; i < SYNC; i++) begin m_a[i] = a; m_r[i] = r; end
      m_mode = 0; m_sel = r; m_chg = 1'b0;
    end else begin
      ns = m_sel; nm = m_mode;
      case (m_mode)
        0: begin ns = m_r[SYNC-1]; if (m_a[SYNC-1]) nm = 1; end
        1: if (!m_a[SYNC-1]) begin nm = 0; ns = m_r[SYNC-1]; end
           else if (l[m_sel]) begin nm = 2; ns = ~m_sel; end
        default: if (!m_a[SYNC-1]) begin nm = 0; ns = m_r[SYNC-1]; end
      endcase
      m_chg = (ns != m_sel);
      m_sel = ns; m_mode = nm;
      for (int i = SYNC-1; i > 0; i--) begin m_a[i] = m_a[i-1]; m_r[i] = m_r[i-1]; end
      m_a[0] = a; m_r[0] = r;
    end
  endtask

  // called just after a negedge: drive, advance one edge, compare at next negedge
  task automatic cyc(input logic a, input logic r, input logic [1:0] l);
    auto_mode_i = a; sel_req_i = r; loss_i = l;
    model_edge(a, r, l);
    @(posedge clk);
    @(negedge clk);
    if (!rst) begin
      check(sel_o == m_sel, sel_tag(m_mode), sel_o, m_sel);
      check(loss_o == l[m_sel], "R2", loss_o, l[m_sel]);
      check(chg_pulse_o == m_chg, "R8", chg_pulse_o, m_chg);
    end
  endtask

  task automatic hold(input int n, input logic a, input logic r, input logic [1:0] l);
    for (int i = 0; i < n; i++) cyc(a, r, l);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    logic a, r;
    logic [1:0] l;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R9: reset with select high
    rst = 1'b1;
    hold(3, 1'b0, 1'b1, 2'b00);
    check(sel_o == 1'b1, "R9", sel_o, 1);
    check(chg_pulse_o == 1'b0, "R9", chg_pulse_o, 0);
    rst = 1'b0;
    // R1: manual select to 0 appears after three edges
    cyc(1'b0, 1'b0, 2'b00);
    cyc(1'b0, 1'b0, 2'b00);
    check(sel_o == 1'b1, "R1", sel_o, 1);
    cyc(1'b0, 1'b0, 2'b00);
    check(sel_o == 1'b0, "R1", sel_o, 0);
    check(chg_pulse_o == 1'b1, "R8", chg_pulse_o, 1);
    cyc(1'b0, 1'b0, 2'b00);
    check(chg_pulse_o == 1'b0, "R8", chg_pulse_o, 0);
    // R3: arm on port 0, select toggles ignored
    hold(4, 1'b1, 1'b0, 2'b00);
    hold(5, 1'b1, 1'b1, 2'b00);
    check(sel_o == 1'b0, "R3", sel_o, 0);
    // R4: port 0 dies, one flip to port 1
    cyc(1'b1, 1'b1, 2'b01);
    check(sel_o == 1'b1, "R4", sel_o, 1);
    check(chg_pulse_o == 1'b1, "R8", chg_pulse_o, 1);
    // R5: both dead, no second move, loss stays high
    hold(6, 1'b1, 1'b0, 2'b11);
    check(sel_o == 1'b1, "R5", sel_o, 1);
    check(loss_o == 1'b1, "R5", loss_o, 1);
    // R6: select toggles after failover are ignored
    hold(3, 1'b1, 1'b1, 2'b01);
    hold(3, 1'b1, 1'b0, 2'b01);
    check(sel_o == 1'b1, "R6", sel_o, 1);
    // R7: mode low returns to manual, follows select (0)
    hold(4, 1'b0, 1'b0, 2'b00);
    check(sel_o == 1'b0, "R7", sel_o, 0);
    // R7: re-arm, fault on port 0 moves again
    hold(4, 1'b1, 1'b0, 2'b00);
    cyc(1'b1, 1'b0, 2'b01);
    check(sel_o == 1'b1, "R7", sel_o, 1);
    hold(4, 1'b0, 1'b1, 2'b00);
    // random phase
    a = 1'b0; r = 1'b1; l = 2'b00;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39) == 0) a = ~a;
      if ($urandom_range(14) == 0) r = ~r;
      if ($urandom_range(19) == 0) l[0] = ~l[0];
      if ($urandom_range(19) == 0) l[1] = ~l[1];
      cyc(a, r, l);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule